// File: doc/BRIEF.md
# Branch Target Cache Predictor

This block sits in the instruction-fetch address loop and remembers where recently taken branches went. Every cycle it looks up the current fetch address in a small fully associative table of branch addresses. When the address is found, the next fetch address becomes the remembered destination, and this takes priority over the sequential path. Otherwise the next fetch address is the current one plus four. The lookup is combinational, so the prediction for a fetch address is available in the same cycle.

The execute stage sends two kinds of correction. The first reports a taken branch that was not predicted. The block redirects fetch to the computed destination and records the branch address and destination pair. The second is an "unbranch", sent when a prediction was wrong. The block redirects fetch to the word after the branch and drops the entry that caused the bad guess. Both repairs cost the same single redirect.

The tag compare is split in two to save power. A low section covers address bits [5:2] and is evaluated on every lookup. A high section covers bits above bit 5. Its per-entry match vector is stored and reused while the upper address bits stay the same, because sequential fetch seldom changes them. The target array is read only when the tag compare hits. One control input turns prediction off. Another forces the full compare on every lookup.

Top module: `btc_predictor`

## Requirements
- R1: While reset is held, and after reset before any correction has been written, the table is empty. `pred_taken` is 0 and `next_addr` equals `fetch_addr + 4`.
- R2: When `pred_en` is 1 and `fetch_addr` (bits [31:2]) equals a stored branch address, `pred_taken` is 1 in the same cycle and `next_addr` is that entry's stored destination.
- R3: When `fetch_addr` matches no stored entry, `pred_taken` is 0 and `next_addr` is `fetch_addr + 4`.
- R4: A pair written by a taken-branch correction can be hit from the following cycle on. A lookup in the same cycle as the write still sees the table as it was before the write.
- R5: A taken-branch correction whose branch address is already stored replaces that entry's destination and uses no new slot.
- R6: A new branch address goes into slots chosen round-robin over all 20 slots. When the table is full, the 21st new address evicts the oldest-written entry.
- R7: An unbranch sets `redir_valid` and `redir_addr = unb_pc + 4` in the same cycle, and removes the entry for `unb_pc`, so that address misses from the next cycle on.
- R8: A taken-branch correction sets `redir_valid` and `redir_addr = upd_target` in the same cycle.
- R9: When an unbranch and a taken-branch correction arrive in the same cycle, the unbranch sets the redirect and the taken-branch pair is not written.
- R10: With `pred_en` at 0, `pred_taken` stays 0 and `next_addr` is always `fetch_addr + 4`. Corrections are still recorded, and they predict once `pred_en` returns to 1.
- R11: The split compare gives the same hit result as a full compare. This holds when the upper bits change, when a write lands while the stored high match is in use, and when `split_en` is 0.
- R12: No fetch address matches more than one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_en | input | 1 | 1 lets table hits redirect fetch |
| split_en | input | 1 | 1 reuses the stored high-section match |
| fetch_valid | input | 1 | The fetch address is live this cycle |
| fetch_addr | input | 32 | Current fetch address |
| next_addr | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | The table redirected this fetch |
| upd_valid | input | 1 | Unpredicted taken branch reported |
| upd_pc | input | 32 | Address of that branch |
| upd_target | input | 32 | Its computed destination |
| unb_valid | input | 1 | Wrong prediction reported (unbranch) |
| unb_pc | input | 32 | Address of the mispredicted branch |
| redir_valid | output | 1 | Fetch must restart this cycle |
| redir_addr | output | 32 | Restart address |

## Verification
The bench works on the stored high match. It places two entries that share bits [5:2] and differ only in their upper bits, and it writes a new entry in the same cycle that the stored high vector is captured. A design that keeps a stale vector would miss the new entry or hit the wrong destination. Table contents are probed at the boundaries: a lookup in the write cycle, an overwrite of an existing address followed by a full-table eviction, and an unbranch that collides with a taken-branch report. Errors there show up as a premature hit, a wrongly evicted slot, or a dropped entry that comes back. Prediction-off and full-compare modes are run on the same streams, and their outputs must follow the table model.

// File: rtl/btc_pkg.sv
package btc_pkg;
   localparam int unsigned BTC_LO_LSB = 2;   // word alignment of fetch addresses

   typedef enum logic [1:0] {
      CORR_NONE     = 2'd0,
      CORR_TAKEN    = 2'd1,
      CORR_UNBRANCH = 2'd2
   } btc_corr_e;
endpackage

// File: rtl/btc_alloc.sv
module btc_alloc #(
   parameter int unsigned ENTRIES = 20,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R6
endmodule

// File: rtl/btc_target_store.sv
module btc_target_store #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ENTRIES = 20,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [ADDR_W-1:0]   wr_tgt,
   input  logic [ENTRIES-1:0]  rd_vec,
   output logic                rd_hit,
   output logic [ADDR_W-1:0]   rd_tgt
);
   logic [ENTRIES-1:0][ADDR_W-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     tgt_q <= '0;
      else if (wr_en) tgt_q[wr_idx] <= wr_tgt;
   end

   // read gated by the hit vector: no hit, no array activity
   assign rd_hit = |rd_vec;
   always_comb begin
      rd_tgt = '0;
      if (rd_hit)
         for (int i = 0; i < ENTRIES; i++)
            if (rd_vec[i]) rd_tgt = rd_tgt | tgt_q[i];
   end
endmodule

// File: rtl/btc_tag_cam.sv
module btc_tag_cam
   import btc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ENTRIES    = 20,
   parameter int unsigned LO_MSB     = 5,
   parameter bit          SPLIT_IMPL = 1'b1,
   localparam int unsigned IDX_W     = $clog2(ENTRIES),
   localparam int unsigned HI_LSB    = LO_MSB + 1,
   localparam int unsigned HI_W      = ADDR_W - HI_LSB,
   localparam int unsigned LO_W      = LO_MSB - BTC_LO_LSB + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               split_en,
   input  logic               fetch_valid,
   input  logic [ADDR_W-1:0]  fetch_addr,
   input  logic [ADDR_W-1:0]  upd_pc,
   input  logic [ADDR_W-1:0]  unb_pc,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRIES-1:0] inv_vec,
   output logic [ENTRIES-1:0] fetch_hit,
   output logic [ENTRIES-1:0] upd_match,
   output logic [ENTRIES-1:0] unb_match,
   output logic [ENTRIES-1:0] vld
);
   logic [ENTRIES-1:0][HI_W-1:0] hi_q;
   logic [ENTRIES-1:0][LO_W-1:0] lo_q;
   logic [ENTRIES-1:0]           vld_q;
   logic [ENTRIES-1:0]           hi_now, lo_now, hi_sel, full_hit;
   logic [HI_W-1:0]              f_hi;
   logic [LO_W-1:0]              f_lo;
   logic                         unused_lsb;

   assign f_hi       = fetch_addr[ADDR_W-1:HI_LSB];
   assign f_lo       = fetch_addr[LO_MSB:BTC_LO_LSB];
   assign vld        = vld_q;
   assign unused_lsb = ^{fetch_addr[BTC_LO_LSB-1:0], upd_pc[BTC_LO_LSB-1:0], unb_pc[BTC_LO_LSB-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         hi_q  <= '0;
         lo_q  <= '0;
      end else begin
         vld_q <= vld_q & ~inv_vec;
         if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            hi_q[wr_idx]  <= upd_pc[ADDR_W-1:HI_LSB];
            lo_q[wr_idx]  <= upd_pc[LO_MSB:BTC_LO_LSB];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < ENTRIES; i++) begin
         hi_now[i]    = vld_q[i] && (hi_q[i] == f_hi);
         lo_now[i]    = (lo_q[i] == f_lo);
         upd_match[i] = vld_q[i] && ({hi_q[i], lo_q[i]} == upd_pc[ADDR_W-1:BTC_LO_LSB]);
         unb_match[i] = vld_q[i] && ({hi_q[i], lo_q[i]} == unb_pc[ADDR_W-1:BTC_LO_LSB]);
         full_hit[i]  = vld_q[i] && ({hi_q[i], lo_q[i]} == fetch_addr[ADDR_W-1:BTC_LO_LSB]);
      end
   end

   if (SPLIT_IMPL) begin : g_split
      logic [ENTRIES-1:0] hc_vec;
      logic [HI_W-1:0]    hc_key;
      logic               hc_ok;
      logic               reuse;

      assign reuse  = split_en && hc_ok && (hc_key == f_hi);
      assign hi_sel = reuse ? hc_vec : hi_now;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hc_ok  <= 1'b0;
            hc_key <= '0;
            hc_vec <= '0;
         end else if (wr_en || (|inv_vec)) begin
            hc_ok  <= 1'b0;          // table changed: stored high match is stale
         end else if (fetch_valid) begin
            hc_ok  <= 1'b1;
            hc_key <= f_hi;
            hc_vec <= hi_sel;
         end
      end
   end else begin : g_full
      logic unused_split;
      assign unused_split = ^{split_en, fetch_valid};
      assign hi_sel = hi_now;
   end

   assign fetch_hit = hi_sel & lo_now;

   if (LO_MSB < BTC_LO_LSB || LO_MSB >= ADDR_W - 1) begin : g_bad_lo
      $error("btc_tag_cam: LO_MSB out of range");
   end

   AST_SPLIT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_hit == full_hit);                                          // R11
   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fetch_hit));                                            // R12
endmodule

// File: rtl/btc_predictor.sv
module btc_predictor
   import btc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned ENTRIES    = 20,
   parameter int unsigned LO_MSB     = 5,
   parameter bit          SPLIT_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_en,
   input  logic              split_en,
   input  logic              fetch_valid,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic [ADDR_W-1:0] next_addr,
   output logic              pred_taken,
   input  logic              upd_valid,
   input  logic [ADDR_W-1:0] upd_pc,
   input  logic [ADDR_W-1:0] upd_target,
   input  logic              unb_valid,
   input  logic [ADDR_W-1:0] unb_pc,
   output logic              redir_valid,
   output logic [ADDR_W-1:0] redir_addr
);
   localparam int unsigned     IDX_W = $clog2(ENTRIES);
   localparam logic [ADDR_W-1:0] INC = ADDR_W'(4);

   btc_corr_e          corr;
   logic [ENTRIES-1:0] fetch_hit, upd_match, unb_match, vld, inv_vec, rd_vec;
   logic [IDX_W-1:0]   ptr, hit_idx, wr_idx;
   logic               do_wr, adv, upd_known, tgt_hit;
   logic [ADDR_W-1:0]  tgt_rd;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("btc_predictor: ENTRIES must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_width
      $error("btc_predictor: ADDR_W too small");
   end

   always_comb begin
      if (unb_valid)      corr = CORR_UNBRANCH;
      else if (upd_valid) corr = CORR_TAKEN;
      else                corr = CORR_NONE;
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (upd_match[i]) hit_idx = IDX_W'(i);
   end

   assign upd_known = |upd_match;
   assign do_wr     = (corr == CORR_TAKEN);
   assign adv       = do_wr && !upd_known;
   assign wr_idx    = upd_known ? hit_idx : ptr;
   assign inv_vec   = (corr == CORR_UNBRANCH) ? unb_match : '0;
   assign rd_vec    = pred_en ? fetch_hit : '0;

   btc_alloc #(.ENTRIES(ENTRIES)) u_alloc (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ptr(ptr)
   );

   btc_tag_cam #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .LO_MSB(LO_MSB),
                 .SPLIT_IMPL(SPLIT_IMPL)) u_cam (
      .clk(clk), .rst_n(rst_n), .split_en(split_en), .fetch_valid(fetch_valid),
      .fetch_addr(fetch_addr), .upd_pc(upd_pc), .unb_pc(unb_pc),
      .wr_en(do_wr), .wr_idx(wr_idx), .inv_vec(inv_vec),
      .fetch_hit(fetch_hit), .upd_match(upd_match), .unb_match(unb_match), .vld(vld)
   );

   btc_target_store #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_tgt (
      .clk(clk), .rst_n(rst_n), .wr_en(do_wr), .wr_idx(wr_idx), .wr_tgt(upd_target),
      .rd_vec(rd_vec), .rd_hit(tgt_hit), .rd_tgt(tgt_rd)
   );

   assign pred_taken  = tgt_hit;
   assign next_addr   = tgt_hit ? tgt_rd : fetch_addr + INC;
   assign redir_valid = (corr != CORR_NONE);
   assign redir_addr  = (corr == CORR_UNBRANCH) ? unb_pc + INC : upd_target;

   AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(vld) < $past($countones(vld))) |-> $past(unb_valid)); // R7
endmodule

// File: tb/btc_predictor_tb.sv
module btc_predictor_tb;
   localparam int N = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pred_en = 1'b1, split_en = 1'b1;
   logic        fetch_valid = 1'b0, upd_valid = 1'b0, unb_valid = 1'b0;
   logic [31:0] fetch_addr = '0, upd_pc = '0, upd_target = '0, unb_pc = '0;
   logic [31:0] next_addr, redir_addr;
   logic        pred_taken, redir_valid;

   int n_chk = 0, n_bad = 0;

   logic        rv [N];
   logic [31:0] rp [N];
   logic [31:0] rt [N];
   int          rptr;

   always #10 clk = ~clk;   // 50 MHz

   btc_predictor u_dut (
      .clk(clk), .rst_n(rst_n), .pred_en(pred_en), .split_en(split_en),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
      .next_addr(next_addr), .pred_taken(pred_taken),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
      .unb_valid(unb_valid), .unb_pc(unb_pc),
      .redir_valid(redir_valid), .redir_addr(redir_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int k = 0; k < N; k++) begin rv[k] = 1'b0; rp[k] = '0; rt[k] = '0; end
      rptr = 0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; fetch_valid = 1'b0; upd_valid = 1'b0; unb_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_clear();
   endtask

   // one cycle: drive at negedge, check combinational outputs, commit model at posedge
   task automatic cyc(input string tag, input logic fv, input logic [31:0] fa,
                      input logic uv, input logic [31:0] up, input logic [31:0] ut,
                      input logic bv, input logic [31:0] bp);
      logic        hit;
      logic [31:0] tg;
      int          idx;
      @(negedge clk);
      fetch_valid = fv; fetch_addr = fa;
      upd_valid = uv; upd_pc = up; upd_target = ut;
      unb_valid = bv; unb_pc = bp;
      #5;
      hit = 1'b0; tg = '0;
      for (int k = 0; k < N; k++) if (rv[k] && rp[k] == fa) begin hit = 1'b1; tg = rt[k]; end
      if (!pred_en) hit = 1'b0;
      chk({tag, " pred_taken"}, {31'd0, pred_taken}, {31'd0, hit});
      chk({tag, " next_addr"}, next_addr, hit ? tg : fa + 32'd4);
      chk({tag, " redir_valid"}, {31'd0, redir_valid}, {31'd0, (uv | bv)});
      if (bv)      chk({tag, " redir_addr"}, redir_addr, bp + 32'd4);
      else if (uv) chk({tag, " redir_addr"}, redir_addr, ut);
      @(posedge clk);
      if (bv) begin
         for (int k = 0; k < N; k++) if (rv[k] && rp[k] == bp) rv[k] = 1'b0;
      end else if (uv) begin
         idx = -1;
         for (int k = 0; k < N; k++) if (rv[k] && rp[k] == up) idx = k;
         if (idx >= 0) rt[idx] = ut;
         else begin
            rv[rptr] = 1'b1; rp[rptr] = up; rt[rptr] = ut;
            rptr = (rptr == N - 1) ? 0 : rptr + 1;
         end
      end
      #1;
   endtask

   task automatic look(input string tag, input logic [31:0] fa);
      cyc(tag, 1'b1, fa, 1'b0, '0, '0, 1'b0, '0);
   endtask

   task automatic learn(input string tag, input logic [31:0] pc, input logic [31:0] tg);
      cyc(tag, 1'b0, 32'h0, 1'b1, pc, tg, 1'b0, '0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; fetch_addr = 32'h40; fetch_valid = 1'b1;
      #5;
      chk("R1 in reset next_addr", next_addr, 32'h44);
      chk("R1 in reset pred_taken", {31'd0, pred_taken}, 32'd0);
      do_reset();
      look("R1 after reset", 32'h100);
   endtask

   task automatic t_learn();
      cyc("R8 R4 same-cycle lookup", 1'b1, 32'h200, 1'b1, 32'h200, 32'h800, 1'b0, '0);
      look("R2 hit", 32'h200);
      look("R3 miss", 32'h204);
      learn("R5 overwrite", 32'h200, 32'h900);
      look("R5 new target", 32'h200);
   endtask

   task automatic t_unbranch();
      cyc("R7 unbranch", 1'b1, 32'h200, 1'b0, '0, '0, 1'b1, 32'h200);
      look("R7 entry gone", 32'h200);
      learn("R9 setup", 32'h400, 32'hC00);
      cyc("R9 collide", 1'b0, 32'h0, 1'b1, 32'h300, 32'hA00, 1'b1, 32'h400);
      look("R9 update dropped", 32'h300);
      look("R9 unbranch applied", 32'h400);
   endtask

   task automatic t_disable();
      pred_en = 1'b0;
      learn("R10 learn while off", 32'h500, 32'hB00);
      look("R10 no prediction", 32'h500);
      pred_en = 1'b1;
      look("R10 predicts when on", 32'h500);
   endtask

   task automatic t_round_robin();
      do_reset();
      for (int k = 0; k < N; k++) learn("R6 fill", 32'h1000 + 32'(k) * 32'h40, 32'h8000 + 32'(k) * 4);
      learn("R5 no slot used", 32'h1000 + 32'h140, 32'hF000);
      learn("R6 evict", 32'h9000, 32'h9100);
      look("R6 oldest evicted", 32'h1000);
      look("R6 second kept", 32'h1040);
      look("R6 newest present", 32'h9000);
      look("R5 overwritten kept", 32'h1140);
   endtask

   task automatic t_split(input string tag);
      do_reset();
      learn({tag, " setup A"}, 32'h1000_0010, 32'h0000_1110);
      learn({tag, " setup B"}, 32'h2000_0010, 32'h0000_2220);
      for (int k = 0; k < 6; k++) look({tag, " seq"}, 32'h1000_0000 + 32'(k) * 4);
      look({tag, " high change"}, 32'h2000_0010);
      look({tag, " high back"}, 32'h1000_0010);
      cyc({tag, " write during reuse"}, 1'b1, 32'h1000_0020, 1'b1, 32'h1000_0028, 32'h3330, 1'b0, '0);
      look({tag, " after write"}, 32'h1000_0024);
      look({tag, " new entry"}, 32'h1000_0028);
      cyc({tag, " idle"}, 1'b0, 32'h2000_0010, 1'b0, '0, '0, 1'b0, '0);
      look({tag, " after idle"}, 32'h2000_0010);
      cyc({tag, " unbranch during reuse"}, 1'b1, 32'h2000_0014, 1'b0, '0, '0, 1'b1, 32'h2000_0010);
      look({tag, " after unbranch"}, 32'h2000_0010);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      model_clear();
      t_reset();
      t_learn();
      t_unbranch();
      t_disable();
      t_round_robin();
      split_en = 1'b1;
      t_split("R11 split R12");
      split_en = 1'b0;
      t_split("R11 full");
      split_en = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule